// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer ALU

This block is a 128-bit integer arithmetic and logic unit for a vector datapath. A 2-bit lane-size select splits the word into 16 byte lanes, 8 halfword lanes, 4 word lanes or 2 doubleword lanes. Addition and subtraction run in every lane at once, and each lane wraps modulo its own width. No carry or borrow reaches the neighbouring lane. The bitwise functions act on all 128 bits, whatever the lane size.

Internally, one carry chain is built from sixteen 8-bit slices. A boundary mask, decoded from the lane-size select, decides where the chain breaks. At a break, the next slice takes the operation's carry-in in place of the ripple carry. The result is registered, so a set of operands presented before a rising edge shows its result right after that edge.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` is all zeros.
- R2: With op 3'b000 (add) and lane select 2'b00, each of the 16 bytes of the result is the sum of the matching operand bytes modulo 256, and no carry enters the next byte.
- R3: With op add and lane select 2'b01, each of the 8 16-bit lanes is the sum modulo 2^16, with no carry between lanes.
- R4: With op add and lane select 2'b10, each of the 4 32-bit lanes is the sum modulo 2^32, with no carry between lanes.
- R5: With op add and lane select 2'b11, each 64-bit half is the sum modulo 2^64, and a carry out of bit 63 does not reach bit 64.
- R6: With op 3'b001 (subtract), each lane of the selected size holds A + ~B + 1 modulo the lane width. The +1 is applied to every lane, and no borrow crosses a lane boundary.
- R7: Ops 3'b010 (AND), 3'b011 (OR), 3'b100 (XOR) and 3'b101 (A AND NOT B) give the bitwise result over all 128 bits, whatever the lane select.
- R8: Op codes 3'b110 and 3'b111 give an all-zero result.
- R9: The result for the inputs sampled at a rising edge appears after that edge. A change of inputs between edges leaves `result_o` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| lane_sel_i | input | 2 | Lane size: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| result_o | output | 128 | Registered result |

## Verification
The case that is hardest to reach is a carry that would have to leave a lane. Random operands produce a carry exactly at a lane boundary only now and then, and they almost never produce one that travels through a whole lane. The stimulus therefore uses directed patterns: all-ones plus one, and zero minus one. In every lane these make a carry or borrow run the full lane width and reach the boundary. These patterns are applied at each of the four lane sizes. Further vectors pair a 64-bit-lane operand with each of the narrower lane selects, so that a boundary that is wrongly opened or closed changes the answer.

// File: rtl/simd_alu_pkg.sv
// Shared types for the lane-partitioned SIMD ALU.
// Assumes a 3-bit operation code; codes not listed here give a zero result.
package simd_alu_pkg;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'b000,
        ALU_SUB  = 3'b001,
        ALU_AND  = 3'b010,
        ALU_OR   = 3'b011,
        ALU_XOR  = 3'b100,
        ALU_ANDN = 3'b101
    } alu_op_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_sel_e;

endpackage

// File: rtl/lane_boundary.sv
// Decodes the lane-size select into a per-slice "lane starts here" mask.
// Assumes lane widths of 1, 2, 4 and 8 slices and a power-of-two slice count.
module lane_boundary #(
    parameter int NUM_SLICES = 16
) (
    input  logic [1:0]            lane_sel,
    output logic [NUM_SLICES-1:0] seg_start
);
    localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    logic [IDX_W-1:0] span_mask;

    // Lane length in slices, minus one, used as a low-bit mask on the slice index.
    always_comb begin
        span_mask = IDX_W'((4'd1 << lane_sel) - 4'd1);
    end

    genvar i;
    generate
        for (i = 0; i < NUM_SLICES; i++) begin : g_start
            localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
            // A slice opens a lane when its index is a multiple of the lane length.
            assign seg_start[i] = ((IDX & span_mask) == '0);
        end
    endgenerate
endmodule

// File: rtl/segmented_adder.sv
// Adder built from slices, with a carry chain broken at each lane start.
// When subtracting, B is inverted and every lane start takes a carry-in of one.
// Assumes seg_start[0] is set.
module segmented_adder #(
    parameter int DATA_W  = 128,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0]         a,
    input  logic [DATA_W-1:0]         b,
    input  logic                      sub,
    input  logic [DATA_W/SLICE_W-1:0] seg_start,
    output logic [DATA_W-1:0]         sum
);
    localparam int NUM_SLICES = DATA_W / SLICE_W;

    logic [DATA_W-1:0]     b_eff;
    logic [NUM_SLICES-1:0] cin;
    logic [NUM_SLICES-1:0] cout;

    // Second operand, inverted for subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_SLICES; i++) begin : g_slice
            // Carry into the slice: fresh at a lane start, otherwise rippled.
            if (i == 0) begin : g_first
                assign cin[i] = seg_start[i] & sub;
            end else begin : g_rest
                assign cin[i] = seg_start[i] ? sub : cout[i-1];
            end

            if (i < NUM_SLICES - 1) begin : g_carry
                logic [SLICE_W:0] full;
                assign full = {1'b0, a[i*SLICE_W +: SLICE_W]}
                            + {1'b0, b_eff[i*SLICE_W +: SLICE_W]}
                            + (SLICE_W+1)'(cin[i]);
                assign sum[i*SLICE_W +: SLICE_W] = full[SLICE_W-1:0];
                assign cout[i] = full[SLICE_W];
            end else begin : g_top
                assign sum[i*SLICE_W +: SLICE_W] = a[i*SLICE_W +: SLICE_W]
                                                 + b_eff[i*SLICE_W +: SLICE_W]
                                                 + SLICE_W'(cin[i]);
                assign cout[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/bitwise_unit.sv
// Bitwise functions over the full word; lane size plays no part here.
// Assumes that an op code it does not handle gives zero.
module bitwise_unit import simd_alu_pkg::*; #(
    parameter int DATA_W = 128
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    // Selects the logic function by op code.
    always_comb begin
        case (alu_op_e'(op))
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_ANDN: res = a & ~b;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/simd_alu.sv
// Top level of the lane-partitioned SIMD ALU: lane decode, segmented adder,
// bitwise unit and the result register.
// Assumes DATA_W is SLICE_W times a power of two, with at least 8 slices.
module simd_alu import simd_alu_pkg::*; #(
    parameter int DATA_W  = 128,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        lane_sel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int NUM_SLICES = DATA_W / SLICE_W;

    logic [NUM_SLICES-1:0] seg_start;
    logic [DATA_W-1:0]     arith_res;
    logic [DATA_W-1:0]     logic_res;
    logic [DATA_W-1:0]     next_res;
    logic                  is_sub;

    lane_boundary #(.NUM_SLICES(NUM_SLICES)) u_bound (
        .lane_sel  (lane_sel_i),
        .seg_start (seg_start)
    );

    // Subtraction selects inversion and a carry-in of one at each lane.
    always_comb begin
        is_sub = (alu_op_e'(op_i) == ALU_SUB);
    end

    segmented_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_add (
        .a         (a_i),
        .b         (b_i),
        .sub       (is_sub),
        .seg_start (seg_start),
        .sum       (arith_res)
    );

    bitwise_unit #(.DATA_W(DATA_W)) u_logic (
        .op  (op_i),
        .a   (a_i),
        .b   (b_i),
        .res (logic_res)
    );

    // Picks the arithmetic or bitwise path; unknown codes give zero.
    always_comb begin
        case (alu_op_e'(op_i))
            ALU_ADD, ALU_SUB:                    next_res = arith_res;
            ALU_AND, ALU_OR, ALU_XOR, ALU_ANDN:  next_res = logic_res;
            default:                             next_res = '0;
        endcase
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= next_res;
    end
endmodule

// File: rtl/simd_alu_chk.sv
// Assertion checker for simd_alu, attached with bind.
// Assumes a 64-bit lane fits within DATA_W and 8-bit slices.
module simd_alu_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op,
    input logic [1:0]        lane,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result
);
    // R8
    bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) >= 3'b110) |-> (result == '0));

    // R7
    xor_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b100) |-> (result == ($past(a) ^ $past(b))));

    // R7
    and_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b010) |-> (result == ($past(a) & $past(b))));

    // R5
    dword_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b000 && $past(lane) == 2'b11)
        |-> (result[63:0] == 64'($past(a[63:0]) + $past(b[63:0]))));

    genvar g;
    generate
        for (g = 0; g < DATA_W/8; g++) begin : g_byte
            // R2
            byte_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(op) == 3'b000 && $past(lane) == 2'b00)
                |-> (result[g*8 +: 8] == 8'($past(a[g*8 +: 8]) + $past(b[g*8 +: 8]))));
        end
    endgenerate
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op_i),
    .lane   (lane_sel_i),
    .a      (a_i),
    .b      (b_i),
    .result (result_o)
);

// File: tb/tb_simd_alu.sv
// Scoreboard bench for simd_alu: the driver queues expected results and the
// monitor compares them after each rising edge.
module tb_simd_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [1:0]   lane_sel_i = '0;
    logic [127:0] a_i = '0;
    logic [127:0] b_i = '0;
    logic [127:0] result_o;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;
    item_t sb_q[$];

    simd_alu dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .lane_sel_i (lane_sel_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .result_o   (result_o)
    );

    always #5 clk = ~clk;

    // Reference model written from the requirements.
    function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] sz,
                                           input logic [127:0] a, input logic [127:0] b);
        int w = 8 << sz;
        logic [127:0] one = 128'd1;
        logic [127:0] mask = (one << w) - one;
        logic [127:0] res = '0;
        case (op)
            3'b010: return a & b;
            3'b011: return a | b;
            3'b100: return a ^ b;
            3'b101: return a & ~b;
            3'b000, 3'b001: begin
                for (int l = 0; l < 128 / w; l++) begin
                    logic [127:0] la = (a >> (l * w)) & mask;
                    logic [127:0] lb = (b >> (l * w)) & mask;
                    logic [127:0] s;
                    if (op == 3'b001) s = (la + ((~lb) & mask) + one) & mask;
                    else              s = (la + lb) & mask;
                    res = res | (s << (l * w));
                end
                return res;
            end
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: applies a vector at the falling edge and queues its expected result.
    task automatic apply(input logic [2:0] op, input logic [1:0] sz,
                         input logic [127:0] a, input logic [127:0] b, input string tag);
        item_t it;
        @(negedge clk);
        op_i = op; lane_sel_i = sz; a_i = a; b_i = b;
        it.exp = model(op, sz, a, b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares the registered result shortly after each rising edge.
    always @(posedge clk) begin
        item_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(it.tag, result_o, it.exp);
        end
    end

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] ones = '1;
        logic [127:0] hold_exp;
        // R1: reset clears the result register
        op_i = 3'b011; a_i = ones; b_i = ones;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", result_o, '0);
        rst_n = 1'b1;

        // R2..R5: carry across each lane width must be cut
        apply(3'b000, 2'b00, ones, 128'h0101_0101_0101_0101_0101_0101_0101_0101, "R2 byte wrap");
        apply(3'b000, 2'b01, ones, 128'h0001_0001_0001_0001_0001_0001_0001_0001, "R3 half wrap");
        apply(3'b000, 2'b10, ones, 128'h00000001_00000001_00000001_00000001, "R4 word wrap");
        apply(3'b000, 2'b11, ones, 128'h0000000000000001_0000000000000001, "R5 dword wrap");
        apply(3'b000, 2'b11, 128'h0_FFFFFFFFFFFFFFFF, 128'h1, "R5 no carry to bit 64");
        apply(3'b000, 2'b00, 128'h0_FFFFFFFFFFFFFFFF, 128'h1, "R2 dword pattern in bytes");
        apply(3'b000, 2'b01, 128'h0_FFFFFFFFFFFFFFFF, 128'h1, "R3 dword pattern in halves");
        apply(3'b000, 2'b10, 128'h0_FFFFFFFFFFFFFFFF, 128'h1, "R4 dword pattern in words");

        // R6: zero minus one per lane and borrow containment
        for (int s = 0; s < 4; s++)
            apply(3'b001, 2'(s), '0, 128'h0101_0101_0101_0101_0101_0101_0101_0101, "R6 borrow");
        for (int s = 0; s < 4; s++)
            apply(3'b001, 2'(s), 128'h5, 128'h5, "R6 equal operands");

        // R7: bitwise ops under every lane select
        for (int o = 2; o < 6; o++)
            for (int s = 0; s < 4; s++)
                apply(3'(o), 2'(s), rnd128(), rnd128(), "R7 bitwise");

        // R8: undefined op codes
        apply(3'b110, 2'b00, ones, ones, "R8 op 6");
        apply(3'b111, 2'b11, ones, 128'h1, "R8 op 7");

        // R2..R6 random mix
        for (int k = 0; k < 200; k++) begin
            logic [2:0] o = 3'($urandom_range(0, 1));
            logic [1:0] s = 2'($urandom_range(0, 3));
            apply(o, s, rnd128(), rnd128(), (o == 3'b001) ? "R6 random" :
                  (s == 2'b00) ? "R2 random" : (s == 2'b01) ? "R3 random" :
                  (s == 2'b10) ? "R4 random" : "R5 random");
        end

        // R9: new inputs show nothing until the next rising edge
        apply(3'b100, 2'b00, 128'h1234, 128'h00FF, "R9 first");
        hold_exp = 128'h12CB;
        @(negedge clk);
        op_i = 3'b011; a_i = ones; b_i = '0;
        #1;
        check("R9 hold between edges", result_o, hold_exp);
        @(posedge clk); #2;
        check("R9 update after edge", result_o, ones);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule